// File: doc/BRIEF.md
# BT.656 Embedded Sync Decoder

This block takes a video stream whose line and frame timing travels inside the data itself, as in ITU-R BT.656. It scans the bus for timing reference codes. Each code is a three-word preamble followed by a flag word. From the flag word it takes the field, vertical-blanking and horizontal-position flags. It turns them into level outputs for line activity, frame activity and field parity. It also passes the active picture samples out with a qualifying strobe.

A mode input selects an 8-bit or 10-bit bus. An enable input switches the decoder on. While the decoder is off, the bus is not interpreted. A second input turns on correction of the flag word using its four protection bits. With correction on, a flag word with a single flipped bit is repaired. A flag word that cannot be repaired raises a sticky error output and is otherwise ignored.

Samples leave the block three clock edges after the edge at which they were taken. The preamble and flag words that end a line are removed from the strobed output.

Top module: `vid_embsync_decoder`

## Requirements
- R1: While `enable` is 0, no reference code is decoded. `line_valid`, `frame_valid` and `field_odd` hold their values. `pix_valid` is 0 once `enable` has been 0 for four consecutive edges.
- R2: With `wide_mode`=0, only `din[7:0]` is used. The preamble is FF,00,00 and the flag word is `din[7:0]`. `pix_out` is `{2'b00, din[7:0]}`, and `din[9:8]` has no effect.
- R3: With `wide_mode`=1, `din[9:0]` is used. The preamble is 3FF,000,000, the flag word is `din[9:2]`, and `pix_out` equals `din`.
- R4: In the flag word, bit 6 is F, bit 5 is V and bit 4 is H. Bits 3..0 are protection bits equal to V^H, F^H, F^V and F^V^H, and bit 7 is 1. After a code is accepted, the outputs are `line_valid`=~H, `frame_valid`=~V and `field_odd`=~F, starting in the cycle after the flag word is sampled.
- R5: Samples that follow a code with H=0 and V=0 appear in order on `pix_out` with `pix_valid`=1, up to the next code. The preamble and flag words of that next code are never strobed. Each sample appears after the third edge following its capture.
- R6: After a code with H=0 and V=1, `line_valid` is 1 and `frame_valid` is 0, and no sample of that line is strobed.
- R7: With `fix_en`=0, the flag bits are taken as received, even when the protection bits disagree, and `xy_err` never rises.
- R8: With `fix_en`=1, a flag word that differs in exactly one of its 8 bits from a valid code is decoded as that valid code.
- R9: With `fix_en`=1, a flag word that differs from every valid code in two or more bits sets `xy_err`, which stays 1 until reset. The three flags keep their previous values.
- R10: After reset, `pix_valid`=0, `line_valid`=0, `frame_valid`=0, `field_odd`=1 and `xy_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns on embedded-code decoding |
| wide_mode | input | 1 | 0: 8-bit bus, 1: 10-bit bus |
| fix_en | input | 1 | Turns on flag word correction |
| din | input | 10 | Incoming video bus |
| pix_out | output | 10 | Delayed sample |
| pix_valid | output | 1 | `pix_out` is an active picture sample |
| line_valid | output | 1 | Inside active part of a line (~H) |
| frame_valid | output | 1 | Outside vertical blanking (~V) |
| field_odd | output | 1 | Current field is the first/odd field (~F) |
| xy_err | output | 1 | Sticky uncorrectable flag word indicator |

## Verification
A wrong flag register shows on the level outputs in the cycle after the flag word is sampled, so the bench checks them right after each code. A wrong per-sample tag in the delay line shows three edges later, as a missing, extra or preamble sample in the strobed stream. The scoreboard catches this as an ordering or value mismatch, or as leftover expected samples at the end. Corrector faults show as the wrong blanking level after a corrupted code, or as a spurious or missing `xy_err`.

// File: rtl/emb_pkg.sv
package emb_pkg;
    localparam int DW = 10;
    localparam int XW = 8;
    localparam int PRE_LEN = 3;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          tag;
    } smp_t;

    typedef struct packed {
        smp_t [PRE_LEN-1:0] sh;
        smp_t               outp;
        logic               f;
        logic               v;
        logic               h;
        logic               err;
    } dec_st_t;

    function automatic logic [XW-1:0] mk_code(input logic f, input logic v, input logic h);
        mk_code = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction
endpackage

// File: rtl/emb_trs_detect.sv
module emb_trs_detect
    import emb_pkg::*;
(
    input  logic          enable,
    input  logic          wide_mode,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] d0,
    input  logic [DW-1:0] d1,
    input  logic [DW-1:0] d2,
    output logic [DW-1:0] smp,
    output logic [XW-1:0] xy,
    output logic          hit
);
    localparam logic [DW-1:0] ONES_W = {DW{1'b1}};
    localparam logic [DW-1:0] ONES_N = {{(DW-XW){1'b0}}, {XW{1'b1}}};

    logic [DW-1:0] lead;

    always_comb begin
        smp  = wide_mode ? din : {{(DW-XW){1'b0}}, din[XW-1:0]};
        xy   = wide_mode ? din[DW-1:DW-XW] : din[XW-1:0];
        lead = wide_mode ? ONES_W : ONES_N;
        hit  = enable && (d2 == lead) && (d1 == '0) && (d0 == '0);
    end
endmodule

// File: rtl/emb_xy_fix.sv
module emb_xy_fix
    import emb_pkg::*;
(
    input  logic          fix_en,
    input  logic [XW-1:0] xy,
    output logic          f,
    output logic          v,
    output logic          h,
    output logic          ok
);
    localparam int NCAND = 8;

    logic [NCAND-1:0] near;

    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        logic [XW-1:0] cw;
        assign cw      = mk_code(c[2], c[1], c[0]);
        assign near[c] = ($countones(cw ^ xy) <= 1);
    end

    always_comb begin
        logic [2:0] pick;
        pick = xy[6:4];
        if (fix_en) begin
            for (int c = 0; c < NCAND; c++) begin
                if (near[c]) pick = 3'(c);
            end
        end
        ok = !fix_en || (|near);
        f  = pick[2];
        v  = pick[1];
        h  = pick[0];
    end
endmodule

// File: rtl/vid_embsync_decoder.sv
module vid_embsync_decoder
    import emb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wide_mode,
    input  logic          fix_en,
    input  logic [9:0]    din,
    output logic [9:0]    pix_out,
    output logic          pix_valid,
    output logic          line_valid,
    output logic          frame_valid,
    output logic          field_odd,
    output logic          xy_err
);
    dec_st_t       st_q, st_d;
    logic [DW-1:0] smp;
    logic [XW-1:0] xy;
    logic          hit;
    logic          fx_f, fx_v, fx_h, fx_ok;

    emb_trs_detect u_det (
        .enable    (enable),
        .wide_mode (wide_mode),
        .din       (din),
        .d0        (st_q.sh[0].data),
        .d1        (st_q.sh[1].data),
        .d2        (st_q.sh[2].data),
        .smp       (smp),
        .xy        (xy),
        .hit       (hit)
    );

    emb_xy_fix u_fix (
        .fix_en (fix_en),
        .xy     (xy),
        .f      (fx_f),
        .v      (fx_v),
        .h      (fx_h),
        .ok     (fx_ok)
    );

    always_comb begin
        st_d             = st_q;
        st_d.outp        = st_q.sh[PRE_LEN-1];
        for (int i = PRE_LEN - 1; i > 0; i--) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
        st_d.sh[0].data  = smp;
        st_d.sh[0].tag   = enable && !st_q.h && !st_q.v;
        if (hit) begin
            // the preamble and flag word are never picture samples
            st_d.outp.tag = 1'b0;
            for (int i = 0; i < PRE_LEN; i++) begin
                st_d.sh[i].tag = 1'b0;
            end
            if (fx_ok) begin
                st_d.f = fx_f;
                st_d.v = fx_v;
                st_d.h = fx_h;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.v   <= 1'b1;
            st_q.h   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_out     = st_q.outp.data;
    assign pix_valid   = st_q.outp.tag;
    assign line_valid  = !st_q.h;
    assign frame_valid = !st_q.v;
    assign field_odd   = !st_q.f;
    assign xy_err      = st_q.err;
endmodule

// File: rtl/emb_dec_chk.sv
module emb_dec_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic fix_en,
    input logic pix_valid,
    input logic line_valid,
    input logic frame_valid,
    input logic field_odd,
    input logic xy_err
);
    logic [2:0] off_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                    off_cnt <= '0;
        else if (enable)               off_cnt <= '0;
        else if (off_cnt != 3'd4)      off_cnt <= off_cnt + 3'd1;
    end

    assert_off_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (off_cnt == 3'd4) |-> !pix_valid);

    assert_off_flags_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(line_valid) && $stable(frame_valid) && $stable(field_odd)));

    assert_err_needs_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xy_err) |-> $past(fix_en));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xy_err |=> xy_err);
endmodule

bind vid_embsync_decoder emb_dec_chk u_chk (.*);

// File: tb/vid_embsync_decoder_tb.sv
module vid_embsync_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       wide_mode = 1'b0;
    logic       fix_en = 1'b0;
    logic [9:0] din = '0;
    logic [9:0] pix_out;
    logic       pix_valid, line_valid, frame_valid, field_odd, xy_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [9:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_embsync_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wide_mode(wide_mode),
        .fix_en(fix_en), .din(din), .pix_out(pix_out), .pix_valid(pix_valid),
        .line_valid(line_valid), .frame_valid(frame_valid),
        .field_odd(field_odd), .xy_err(xy_err)
    );

    function automatic logic [7:0] code(input logic f, input logic v, input logic h);
        code = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a sample is strobed (R5)
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (exp_q.size() == 0) chk("R5 unexpected sample", pix_out, 10'h3FF);
            else chk("R5 sample", pix_out, exp_q.pop_front());
        end
    end

    task automatic send(input logic [9:0] v, input bit exp);
        @(negedge clk);
        din = v;
        if (exp) exp_q.push_back(wide_mode ? v : {2'b00, v[7:0]});
    endtask

    task automatic trs(input logic [7:0] xy);
        if (wide_mode) begin
            send(10'h3FF, 0); send(10'h000, 0); send(10'h000, 0); send({xy, 2'b00}, 0);
        end else begin
            // upper bits driven with junk: must be ignored (R2)
            send(10'h3FF, 0); send(10'h300, 0); send(10'h300, 0); send({2'b11, xy}, 0);
        end
        @(posedge clk); #1;
    endtask

    task automatic pixels(input int n, input bit exp);
        for (int i = 0; i < n; i++)
            send(wide_mode ? 10'(10'h100 + i * 7) : {2'b11, 8'(8'h20 + i * 5)}, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(10'h210, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 pix_valid", 10'(pix_valid), 0);
        chk("R10 line_valid", 10'(line_valid), 0);
        chk("R10 frame_valid", 10'(frame_valid), 0);
        chk("R10 field_odd", 10'(field_odd), 1);
        chk("R10 xy_err", 10'(xy_err), 0);
        @(negedge clk); rst_n = 1'b1; enable = 1'b1;
        idle(4);

        // 8-bit active line, field 1 (R2, R4, R5)
        trs(code(0, 0, 0));
        chk("R4 line_valid after SAV", 10'(line_valid), 1);
        chk("R4 frame_valid", 10'(frame_valid), 1);
        chk("R4 field_odd", 10'(field_odd), 1);
        pixels(6, 1);
        trs(code(0, 0, 1));
        chk("R4 line_valid after EAV", 10'(line_valid), 0);
        idle(3);

        // vertical blanking line (R6)
        trs(code(0, 1, 0));
        chk("R6 line_valid", 10'(line_valid), 1);
        chk("R6 frame_valid", 10'(frame_valid), 0);
        pixels(5, 0);
        trs(code(0, 1, 1));
        idle(3);

        // second field (R4)
        trs(code(1, 0, 0));
        chk("R4 field_odd even field", 10'(field_odd), 0);
        pixels(4, 1);
        trs(code(1, 0, 1));
        idle(3);

        // 10-bit line (R3)
        wide_mode = 1'b1;
        idle(3);
        trs(code(0, 0, 0));
        chk("R3 line_valid", 10'(line_valid), 1);
        chk("R3 field_odd", 10'(field_odd), 1);
        pixels(7, 1);
        trs(code(0, 0, 1));
        chk("R3 line_valid after EAV", 10'(line_valid), 0);
        idle(3);
        wide_mode = 1'b0;
        idle(3);

        // corrupted V bit, correction off: taken raw (R7)
        trs(8'hA0);
        chk("R7 raw V taken", 10'(frame_valid), 0);
        chk("R7 no error", 10'(xy_err), 0);
        pixels(3, 0);
        trs(code(0, 0, 1));
        idle(3);

        // correction on: single-bit errors repaired (R8)
        fix_en = 1'b1;
        trs(8'hA0);
        chk("R8 V repaired", 10'(frame_valid), 1);
        chk("R8 H repaired", 10'(line_valid), 1);
        pixels(5, 1);
        trs(8'h9C);
        chk("R8 EAV repaired", 10'(line_valid), 0);
        chk("R8 no error", 10'(xy_err), 0);
        idle(3);

        // uncorrectable code (R9)
        trs(8'hE0);
        chk("R9 xy_err set", 10'(xy_err), 1);
        chk("R9 line_valid held", 10'(line_valid), 0);
        chk("R9 frame_valid held", 10'(frame_valid), 1);
        pixels(3, 0);
        trs(code(0, 0, 1));
        idle(3);

        // disabled: codes ignored (R1)
        enable = 1'b0;
        idle(5);
        trs(code(1, 1, 0));
        chk("R1 line_valid held", 10'(line_valid), 0);
        chk("R1 field_odd held", 10'(field_odd), 1);
        pixels(4, 0);
        chk("R9 xy_err still set", 10'(xy_err), 1);
        idle(6);
        chk("R5 all expected samples seen", 10'(exp_q.size()), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule